// File: doc/BRIEF.md
# Read-Priority Write Arbiter for a Slow-Write Memory Array

This block sits in front of a memory array whose writes take far longer than its reads. It accepts read commands on one port and buffers write commands in a small FIFO. It issues one command at a time to the array. When a read and a buffered write are both waiting and the array is free, the read is issued first.

A write that is already running can be cut short by an incoming read. This happens only if the write has made enough progress and the write buffer still has free space. The array then receives a one-cycle cancel, and the read starts on the following cycle. The cancelled write stays at the head of the buffer and is later reissued from the beginning. Each cancellation increments a counter, so the cost of repeated writes can be measured.

Top module: `rdpri_wr_arbiter`

## Requirements
- R1: When the array is idle and `rd_valid` is high, the read is issued (`arr_cmd_valid`=1, `arr_cmd_write`=0) even if the write buffer holds entries. A write is issued only in an idle cycle with no pending read.
- R2: The write buffer holds `WB_DEPTH` (default 4) entries. The entry being written counts as one of them. Writes reach the array in arrival order with their address and data. `wr_ready` is 0 while the buffer is full.
- R3: A read issued in cycle n produces `done_valid`=1 with `done_write`=0 in cycle n+`RD_LAT` (default 2).
- R4: A write issued in cycle n that is not cancelled produces `done_valid`=1 with `done_write`=1 in cycle n+`WR_LAT` (default 10), and leaves the buffer.
- R5: A cancelled write asserts `arr_cancel` for exactly one cycle and produces no done pulse.
- R6: Write progress is the number of cycles the write has been active. It is 0 in the first cycle after issue. A cancel happens only when progress is at least the threshold (`ABORT_PCT`% of `WR_LAT`, default 5) and below `WR_LAT`-1. A read that waits from the start of a write therefore cancels it in cycle issue+threshold+1. A read that arrives in the write's final cycle waits for completion.
- R7: No cancel happens while the write buffer is full. The read waits for the write to complete.
- R8: After a cancel, the waiting read is issued in the next cycle. The cancelled write is later reissued with the same address and data.
- R9: `abort_count` resets to 0 and increases by exactly 1 per cancel.
- R10: After reset `rd_ready`=1 and `wr_ready`=1. `rd_ready` is 0 in every cycle in which a read or write is active in the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_valid | input | 1 | Read request, held until accepted |
| rd_addr | input | AW | Read address |
| rd_ready | output | 1 | Read accepted in this cycle when high together with rd_valid |
| wr_valid | input | 1 | Write request into the buffer |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| wr_ready | output | 1 | Buffer has a free entry |
| arr_cmd_valid | output | 1 | One-cycle command issue to the array |
| arr_cmd_write | output | 1 | Issued command is a write |
| arr_cmd_addr | output | AW | Issued command address |
| arr_cmd_data | output | DW | Issued write data (0 for reads) |
| arr_cancel | output | 1 | Cancel the write in flight |
| done_valid | output | 1 | One-cycle completion pulse |
| done_write | output | 1 | Completed command was a write |
| abort_count | output | CNT_W | Number of cancelled writes |

## Verification
The hardest situation to reach from the ports is a read that waits on a write and crosses the progress threshold at a known cycle. Reaching it also requires the buffer to hold free space. The stimulus pushes one write and raises a read two cycles after the write issues. This places the cancel at a predictable cycle. The waiting read is then expected next, followed by the reissued write.

The full-buffer exclusion needs four writes pushed back to back, so that the entry in flight fills the last slot before the read arrives. The final-cycle exclusion uses a read raised exactly in the write's completion cycle.

// File: rtl/rdpri_arb_pkg.sv
package rdpri_arb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } arb_state_e;

  // progress level at which a waiting read may cancel a write
  function automatic int unsigned abort_level(int unsigned wr_lat, int unsigned pct);
    return (wr_lat * pct) / 100;
  endfunction

  // cancel window: at or above the level, and not in the final write cycle
  function automatic logic in_abort_window(int unsigned prog, int unsigned level,
                                           int unsigned wr_lat);
    return (prog >= level) && (prog < wr_lat - 1);
  endfunction

endpackage

// File: rtl/rdpri_wbuf.sv
module rdpri_wbuf #(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [AW-1:0] head_addr,
  output logic [DW-1:0] head_data,
  output logic          empty,
  output logic          full
);
  localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);
  localparam logic [CNTW-1:0] FULL_V = CNTW'(DEPTH);
  localparam logic [PTRW-1:0] LAST_V = PTRW'(DEPTH - 1);

  logic [AW-1:0]   addr_q [DEPTH];
  logic [DW-1:0]   data_q [DEPTH];
  logic [PTRW-1:0] rd_ptr, wr_ptr;
  logic [CNTW-1:0] count;

  assign empty     = (count == '0);
  assign full      = (count == FULL_V);
  assign head_addr = addr_q[rd_ptr];
  assign head_data = data_q[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[wr_ptr] <= push_addr;
      data_q[wr_ptr] <= push_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST_V) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == LAST_V) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/rdpri_timer.sv
module rdpri_timer #(
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          run,
  output logic [PW-1:0] prog
);
  always_ff @(posedge clk) begin
    if (!rst_n)     prog <= '0;
    else if (start) prog <= '0;
    else if (run)   prog <= prog + 1'b1;
  end
endmodule

// File: rtl/rdpri_ctrl.sv
module rdpri_ctrl
  import rdpri_arb_pkg::*;
#(
  parameter int RD_LAT    = 2,
  parameter int WR_LAT    = 10,
  parameter int ABORT_PCT = 50,
  parameter int PW        = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_valid,
  input  logic          buf_empty,
  input  logic          buf_full,
  input  logic [PW-1:0] prog,
  output logic          issue_rd,
  output logic          issue_wr,
  output logic          cancel,
  output logic          rd_done,
  output logic          wr_done,
  output logic          busy
);
  localparam int unsigned LEVEL = abort_level(WR_LAT, ABORT_PCT);
  localparam logic [PW-1:0] RD_LAST = PW'(RD_LAT - 1);
  localparam logic [PW-1:0] WR_LAST = PW'(WR_LAT - 1);

  arb_state_e st, st_nx;

  assign busy     = (st != ST_IDLE);
  assign issue_rd = (st == ST_IDLE) && rd_valid;
  assign issue_wr = (st == ST_IDLE) && !rd_valid && !buf_empty;
  assign rd_done  = (st == ST_READ) && (prog == RD_LAST);
  assign wr_done  = (st == ST_WRITE) && (prog == WR_LAST);
  assign cancel   = (st == ST_WRITE) && rd_valid && !buf_full &&
                    in_abort_window(int'(prog), LEVEL, WR_LAT);

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE:  if (issue_rd) st_nx = ST_READ;
                else if (issue_wr) st_nx = ST_WRITE;
      ST_READ:  if (rd_done) st_nx = ST_IDLE;
      ST_WRITE: if (wr_done || cancel) st_nx = ST_IDLE;
      default:  st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nx;
  end
endmodule

// File: rtl/rdpri_wr_arbiter.sv
module rdpri_wr_arbiter
  import rdpri_arb_pkg::*;
#(
  parameter int AW        = 8,
  parameter int DW        = 16,
  parameter int RD_LAT    = 2,
  parameter int WR_LAT    = 10,
  parameter int ABORT_PCT = 50,
  parameter int WB_DEPTH  = 4,
  parameter int CNT_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_valid,
  input  logic [AW-1:0]    rd_addr,
  output logic             rd_ready,
  input  logic             wr_valid,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  output logic             wr_ready,
  output logic             arr_cmd_valid,
  output logic             arr_cmd_write,
  output logic [AW-1:0]    arr_cmd_addr,
  output logic [DW-1:0]    arr_cmd_data,
  output logic             arr_cancel,
  output logic             done_valid,
  output logic             done_write,
  output logic [CNT_W-1:0] abort_count
);
  localparam int MAX_LAT  = (WR_LAT > RD_LAT) ? WR_LAT : RD_LAT;
  localparam int PW       = (MAX_LAT > 1) ? $clog2(MAX_LAT) : 1;
  localparam int ABORT_TH = int'(abort_level(WR_LAT, ABORT_PCT));

  // named internal events
  logic          buf_push, buf_empty, buf_full;
  logic          ev_issue_rd, ev_issue_wr, ev_cancel, ev_rd_done, ev_wr_done, ev_busy;
  logic [AW-1:0] head_addr;
  logic [DW-1:0] head_data;
  logic [PW-1:0] wr_prog;

  assign wr_ready = !buf_full;
  assign buf_push = wr_valid && !buf_full;
  assign rd_ready = !ev_busy;

  rdpri_wbuf #(.AW(AW), .DW(DW), .DEPTH(WB_DEPTH)) u_wbuf (
    .clk(clk), .rst_n(rst_n),
    .push(buf_push), .push_addr(wr_addr), .push_data(wr_data),
    .pop(ev_wr_done),
    .head_addr(head_addr), .head_data(head_data),
    .empty(buf_empty), .full(buf_full)
  );

  rdpri_timer #(.PW(PW)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .start(ev_issue_rd || ev_issue_wr), .run(ev_busy),
    .prog(wr_prog)
  );

  rdpri_ctrl #(.RD_LAT(RD_LAT), .WR_LAT(WR_LAT), .ABORT_PCT(ABORT_PCT), .PW(PW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .rd_valid(rd_valid), .buf_empty(buf_empty), .buf_full(buf_full),
    .prog(wr_prog),
    .issue_rd(ev_issue_rd), .issue_wr(ev_issue_wr), .cancel(ev_cancel),
    .rd_done(ev_rd_done), .wr_done(ev_wr_done), .busy(ev_busy)
  );

  assign arr_cmd_valid = ev_issue_rd || ev_issue_wr;
  assign arr_cmd_write = ev_issue_wr;
  assign arr_cmd_addr  = ev_issue_wr ? head_addr : rd_addr;
  assign arr_cmd_data  = ev_issue_wr ? head_data : '0;
  assign arr_cancel    = ev_cancel;
  assign done_valid    = ev_rd_done || ev_wr_done;
  assign done_write    = ev_wr_done;

  always_ff @(posedge clk) begin
    if (!rst_n)         abort_count <= '0;
    else if (ev_cancel) abort_count <= abort_count + 1'b1;
  end
endmodule

// File: rtl/rdpri_arb_chk.sv
module rdpri_arb_chk #(
  parameter int PW   = 4,
  parameter int TH   = 5,
  parameter int CW   = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic          wr_ready,
  input logic          arr_cmd_valid,
  input logic          arr_cmd_write,
  input logic          arr_cancel,
  input logic          done_valid,
  input logic [PW-1:0] prog,
  input logic [CW-1:0] abort_count
);
  localparam logic [PW-1:0] TH_V = PW'(TH);

  // R1
  read_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_cmd_valid && arr_cmd_write) |-> !rd_valid);

  // R5
  cancel_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_cancel |-> !done_valid);

  // R6
  cancel_threshold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_cancel |-> (prog >= TH_V));

  // R7
  cancel_not_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_cancel |-> wr_ready);

  // R8
  read_after_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_cancel |=> (arr_cmd_valid && !arr_cmd_write));

  // R9
  abort_incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_cancel |=> (abort_count == $past(abort_count) + 1'b1));

  // R9
  abort_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !arr_cancel |=> $stable(abort_count));

  // R10
  busy_blocks_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_cmd_valid |=> !rd_ready);
endmodule

bind rdpri_wr_arbiter rdpri_arb_chk #(.PW(PW), .TH(ABORT_TH), .CW(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .wr_ready(wr_ready), .arr_cmd_valid(arr_cmd_valid), .arr_cmd_write(arr_cmd_write),
  .arr_cancel(arr_cancel), .done_valid(done_valid), .prog(wr_prog),
  .abort_count(abort_count)
);

// File: tb/sim_rdpri_wr_arbiter.sv
`timescale 1ns/1ps
module sim_rdpri_wr_arbiter;
  localparam int RDL = 2;
  localparam int WRL = 10;
  localparam int THR = WRL / 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_valid = 1'b0, wr_valid = 1'b0;
  logic [7:0]  rd_addr = '0, wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        rd_ready, wr_ready, arr_cmd_valid, arr_cmd_write, arr_cancel;
  logic        done_valid, done_write;
  logic [7:0]  arr_cmd_addr;
  logic [15:0] arr_cmd_data, abort_count;

  always #5 clk = ~clk;

  rdpri_wr_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
    .arr_cmd_valid(arr_cmd_valid), .arr_cmd_write(arr_cmd_write),
    .arr_cmd_addr(arr_cmd_addr), .arr_cmd_data(arr_cmd_data), .arr_cancel(arr_cancel),
    .done_valid(done_valid), .done_write(done_write), .abort_count(abort_count)
  );

  typedef struct { bit w; logic [7:0] a; logic [15:0] d; } exp_t;
  exp_t q[$];

  int nchk = 0, nfail = 0, cyc = 0, cancels = 0, cancel_dist = 0;
  int last_issue = 0, last_wr_issue = 0;
  bit last_w = 1'b0, finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic expect_cmd(bit w, logic [7:0] a, logic [15:0] d);
    exp_t e;
    e.w = w; e.a = a; e.d = d;
    q.push_back(e);
  endtask

  // monitor: scoreboard of issued commands, done timing, cancels
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (arr_cmd_valid) begin
        if (q.size() == 0) chk(1'b0, "R1", "unexpected command", arr_cmd_addr, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk(arr_cmd_write == e.w, "R1", "command type", arr_cmd_write, e.w);
          chk(arr_cmd_addr == e.a, "R2/R8", "command address", arr_cmd_addr, e.a);
          if (e.w) chk(arr_cmd_data == e.d, "R2/R8", "write data", arr_cmd_data, e.d);
        end
        last_issue = cyc;
        last_w = arr_cmd_write;
        if (arr_cmd_write) last_wr_issue = cyc;
      end
      if (done_valid) begin
        chk(done_write == last_w, "R3/R4", "done type", done_write, last_w);
        chk(cyc - last_issue == (last_w ? WRL : RDL), "R3/R4", "done latency",
            cyc - last_issue, last_w ? WRL : RDL);
      end
      if (arr_cancel) begin
        cancels++;
        cancel_dist = cyc - last_wr_issue;
        chk(!done_valid, "R5", "done during cancel", done_valid, 0);
      end
    end
  end

  // callers are at a negedge
  task automatic rd_req(logic [7:0] a);
    bit hs;
    rd_valid = 1'b1; rd_addr = a;
    do begin #2; hs = rd_ready; @(negedge clk); end while (!hs);
    rd_valid = 1'b0;
  endtask

  task automatic wr_push(logic [7:0] a, logic [15:0] d);
    bit hs;
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    do begin #2; hs = wr_ready; @(negedge clk); end while (!hs);
    wr_valid = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    repeat (WRL + 2) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    summary();
  end

  initial begin
    int c0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R10 reset state
    chk(rd_ready == 1'b1, "R10", "rd_ready after reset", rd_ready, 1);
    chk(wr_ready == 1'b1, "R2", "wr_ready after reset", wr_ready, 1);
    chk(abort_count == 0, "R9", "abort_count after reset", abort_count, 0);
    chk(arr_cmd_valid == 1'b0, "R1", "idle command", arr_cmd_valid, 0);
    @(negedge clk);

    // R1: read and queued write both pending when array frees
    expect_cmd(0, 8'h31, 0);
    expect_cmd(0, 8'h32, 0);
    expect_cmd(1, 8'h11, 16'h1111);
    rd_req(8'h31);
    fork
      wr_push(8'h11, 16'h1111);
      rd_req(8'h32);
    join
    drain();

    // R5 R6 R8 R9: read raised early cancels at threshold
    expect_cmd(1, 8'h20, 16'hA5A5);
    expect_cmd(0, 8'h40, 0);
    expect_cmd(1, 8'h20, 16'hA5A5);
    wr_push(8'h20, 16'hA5A5);
    @(negedge clk);
    #2;
    chk(rd_ready == 1'b0, "R10", "rd_ready during write", rd_ready, 0);
    @(negedge clk);
    rd_req(8'h40);
    chk(cancels == 1, "R5", "cancel count", cancels, 1);
    chk(cancel_dist == THR + 1, "R6", "cancel cycle after issue", cancel_dist, THR + 1);
    drain();
    chk(abort_count == 1, "R9", "abort_count after cancel", abort_count, 1);

    // R6: read raised in final write cycle waits
    expect_cmd(1, 8'h21, 16'h5A5A);
    expect_cmd(0, 8'h41, 0);
    wr_push(8'h21, 16'h5A5A);
    repeat (WRL) @(negedge clk);
    c0 = cancels;
    rd_req(8'h41);
    drain();
    chk(cancels == c0, "R6", "no cancel in final cycle", cancels, c0);
    chk(abort_count == 1, "R9", "abort_count unchanged", abort_count, 1);

    // R7 R2: full buffer blocks cancel
    expect_cmd(1, 8'h50, 16'h0101);
    expect_cmd(0, 8'h42, 0);
    expect_cmd(1, 8'h51, 16'h0202);
    expect_cmd(1, 8'h52, 16'h0303);
    expect_cmd(1, 8'h53, 16'h0404);
    wr_push(8'h50, 16'h0101);
    wr_push(8'h51, 16'h0202);
    wr_push(8'h52, 16'h0303);
    wr_push(8'h53, 16'h0404);
    #2;
    chk(wr_ready == 1'b0, "R2", "wr_ready when full", wr_ready, 0);
    @(negedge clk);
    c0 = cancels;
    rd_req(8'h42);
    drain();
    chk(cancels == c0, "R7", "no cancel while full", cancels, c0);
    chk(abort_count == 1, "R7", "abort_count with full buffer", abort_count, 1);
    chk(q.size() == 0, "R1", "all commands issued", q.size(), 0);
    summary();
  end
endmodule